// File: doc/BRIEF.md
# Sub-word Load/Store Lane Aligner

This block sits between a load/store unit and a small data memory whose rows are eight bytes wide. Each request carries a byte address, a width code, a direction and an optional byte-reversal flag. A load picks the addressed row, cuts out the bytes of the requested width at the addressed offset, and returns them right-aligned with the upper bits zero. A store merges a narrow value into the row in one read-modify-write step and leaves the other bytes of the row as they were.

Lanes are placed little-endian by offset: the byte at the lowest offset of the access maps to bits 7:0 of the value. When byte reversal is requested, the value is reversed over its own width. On a load the reversal is applied after extraction, and on a store it is applied before the merge. Accesses whose offset is not a multiple of their width are never split. They are rejected with a one-cycle alignment-error pulse. The row storage is a behavioural register array held in the block and cleared by reset.

Top module: `lsu_lane_aligner`

## Requirements
- R1: The row index is address bits [3 +: log2(DEPTH)] and the byte offset is address bits [2:0]. Address bits above the row index are ignored, so addresses that differ only there reach the same row.
- R2: The width code selects the access size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. Codes 4 to 7 are illegal. They raise the alignment error, return no data and write nothing.
- R3: An access whose offset is not a multiple of its width raises `rsp_align_err` for exactly one cycle, one cycle after the request. It leaves the row unchanged, and `rsp_valid` stays low with `rsp_rdata` at zero.
- R4: A legal load raises `rsp_valid` for one cycle, one cycle after the request, with the data in `rsp_rdata`. Whenever `rsp_valid` is low, `rsp_rdata` is zero.
- R5: A narrow load returns bytes offset to offset+width-1 of the row, right-aligned. The byte at the lowest offset lands in bits 7:0 and all bits above the width are zero.
- R6: An 8-byte load returns the whole row unchanged.
- R7: A narrow store replaces only the bytes offset to offset+width-1, taking them from the low bytes of the write data. Write-data bits above the width are ignored, and the new row is visible to a load issued in the very next cycle.
- R8: An 8-byte store replaces the whole row.
- R9: With swap set, the value is byte-reversed over the access width. For a load this happens after extraction, and for a store it happens before the merge. This applies to the 8-byte width as well.
- R10: Reset clears every row to zero and drives all outputs low. A load from a row not written since reset returns zero.
- R11: A store never raises `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_size | input | 3 | Width code (0:1B, 1:2B, 2:4B, 3:8B) |
| req_swap | input | 1 | Byte-reverse the access value |
| req_addr | input | 64 | Byte address |
| req_wdata | input | 64 | Store value, right-aligned |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | 64 | Right-aligned load data |
| rsp_align_err | output | 1 | Misaligned or illegal-width request pulse |

## Verification
The bench first checks a byte store whose write data has all-ones upper bits. A design that forgot to mask the incoming value would smear those ones across the neighbouring bytes, and the full-row readback that follows exposes this. It then runs half-word and word accesses with swap set at non-zero offsets, where a design that reverses over the whole row, or reverses before extracting, returns the bytes in the wrong lanes. Misaligned and illegal-width stores are each followed by a readback of the same row, so a design that still performed the write is caught. Finally, aliased high addresses, back-to-back store then load, and a reset in mid-run target wrong row decoding, a stale read path, and memory that survives reset.

// File: rtl/lal_pkg.sv
package lal_pkg;
   // width codes shared by the aligner and its users
   localparam logic [2:0] LAL_SZ_BYTE  = 3'd0;
   localparam logic [2:0] LAL_SZ_HALF  = 3'd1;
   localparam logic [2:0] LAL_SZ_WORD  = 3'd2;
   localparam logic [2:0] LAL_SZ_DWORD = 3'd3;
endpackage

// File: rtl/lal_decode.sv
module lal_decode #(
   parameter int ADDR_W    = 64,
   parameter int ROW_BYTES = 8,
   parameter int DEPTH     = 16,
   localparam int DATA_W   = ROW_BYTES * 8,
   localparam int OFF_W    = $clog2(ROW_BYTES),
   localparam int IDX_W    = $clog2(DEPTH),
   localparam int NSZ      = OFF_W + 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        size,
   output logic [IDX_W-1:0]  idx,
   output logic [OFF_W-1:0]  off,
   output logic [DATA_W-1:0] vmask,
   output logic              full,
   output logic              legal
);
   logic [DATA_W-1:0] size_mask [NSZ];
   logic              size_ok;
   logic              aligned;
   logic              unused_hi;

   // elaboration-time parameter checks
   if (ROW_BYTES < 2 || ROW_BYTES != (1 << OFF_W) || OFF_W > 7) begin : g_bad_row
      $error("lal_decode: ROW_BYTES must be a power of two between 2 and 128");
   end
   if (DEPTH < 2 || DEPTH != (1 << IDX_W)) begin : g_bad_depth
      $error("lal_decode: DEPTH must be a power of two of at least 2");
   end
   if (ADDR_W <= OFF_W + IDX_W) begin : g_bad_addr
      $error("lal_decode: ADDR_W too small for row index and offset");
   end

   // one right-aligned value mask per legal width
   for (genvar g = 0; g < NSZ; g++) begin : g_mask
      if (g == OFF_W) begin : g_full
         assign size_mask[g] = '1;
      end else begin : g_part
         assign size_mask[g] = (DATA_W'(1) << (8 * (1 << g))) - DATA_W'(1);
      end
   end

   assign idx       = addr[OFF_W +: IDX_W];
   assign off       = addr[OFF_W-1:0];
   assign unused_hi = ^addr[ADDR_W-1:OFF_W+IDX_W];

   always_comb begin
      vmask   = '0;
      size_ok = 1'b0;
      aligned = 1'b0;
      for (int k = 0; k < NSZ; k++) begin
         if (size == 3'(k)) begin
            vmask   = size_mask[k];
            size_ok = 1'b1;
            aligned = ((off & OFF_W'((1 << k) - 1)) == '0);
         end
      end
   end

   assign full  = (size == 3'(OFF_W));
   assign legal = size_ok & aligned;
endmodule

// File: rtl/lal_swap.sv
module lal_swap #(
   parameter int ROW_BYTES = 8,
   localparam int DATA_W   = ROW_BYTES * 8,
   localparam int OFF_W    = $clog2(ROW_BYTES),
   localparam int NSZ      = OFF_W + 1
) (
   input  logic [DATA_W-1:0] din,
   input  logic [2:0]        size,
   output logic [DATA_W-1:0] dout
);
   logic [DATA_W-1:0] rev [NSZ];

   // byte reversal over each legal width; bytes above the width read zero
   for (genvar k = 0; k < NSZ; k++) begin : g_width
      localparam int NB = 1 << k;
      for (genvar i = 0; i < ROW_BYTES; i++) begin : g_byte
         if (i < NB) begin : g_in
            assign rev[k][8*i +: 8] = din[8*(NB-1-i) +: 8];
         end else begin : g_out
            assign rev[k][8*i +: 8] = 8'h00;
         end
      end
   end

   always_comb begin
      dout = '0;
      for (int k = 0; k < NSZ; k++) begin
         if (size == 3'(k)) dout = rev[k];
      end
   end
endmodule

// File: rtl/lal_rowmem.sv
module lal_rowmem #(
   parameter int ROW_BYTES = 8,
   parameter int DEPTH     = 16,
   localparam int DATA_W   = ROW_BYTES * 8,
   localparam int IDX_W    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] rd_row,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_row
);
   logic [DATA_W-1:0] rows [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < DEPTH; r++) rows[r] <= '0;
      end else if (wr_en) begin
         rows[idx] <= wr_row;
      end
   end

   assign rd_row = rows[idx];
endmodule

// File: rtl/lsu_lane_aligner.sv
module lsu_lane_aligner #(
   parameter int ADDR_W    = 64,
   parameter int ROW_BYTES = 8,
   parameter int DEPTH     = 16,
   localparam int DATA_W   = ROW_BYTES * 8,
   localparam int OFF_W    = $clog2(ROW_BYTES),
   localparam int IDX_W    = $clog2(DEPTH),
   localparam int SH_W     = OFF_W + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_we,
   input  logic [2:0]        req_size,
   input  logic              req_swap,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_align_err
);
   logic [IDX_W-1:0]  idx;
   logic [OFF_W-1:0]  off;
   logic [DATA_W-1:0] vmask;
   logic              full;
   logic              legal;
   logic [SH_W-1:0]   shift;
   logic [DATA_W-1:0] row;
   logic [DATA_W-1:0] ld_ext, ld_rev, ld_val;
   logic [DATA_W-1:0] st_in, st_rev, st_val, merged;
   logic              wr_en;
   logic              ld_ok;

   lal_decode #(.ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES), .DEPTH(DEPTH)) u_dec (
      .addr(req_addr), .size(req_size), .idx(idx), .off(off),
      .vmask(vmask), .full(full), .legal(legal)
   );

   lal_rowmem #(.ROW_BYTES(ROW_BYTES), .DEPTH(DEPTH)) u_mem (
      .clk(clk), .rst_n(rst_n), .idx(idx), .rd_row(row),
      .wr_en(wr_en), .wr_row(merged)
   );

   assign shift = {off, 3'b000};

   // load path: extract lane, then optional reversal
   assign ld_ext = full ? row : ((row >> shift) & vmask);
   lal_swap #(.ROW_BYTES(ROW_BYTES)) u_ld_swap (.din(ld_ext), .size(req_size), .dout(ld_rev));
   assign ld_val = req_swap ? ld_rev : ld_ext;

   // store path: trim value, optional reversal, then merge into the row
   assign st_in = req_wdata & vmask;
   lal_swap #(.ROW_BYTES(ROW_BYTES)) u_st_swap (.din(st_in), .size(req_size), .dout(st_rev));
   assign st_val = req_swap ? st_rev : st_in;
   assign merged = full ? st_val : ((row & ~(vmask << shift)) | (st_val << shift));

   assign wr_en = req_valid & req_we & legal;
   assign ld_ok = req_valid & ~req_we & legal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_rdata     <= '0;
         rsp_align_err <= 1'b0;
      end else begin
         rsp_valid     <= ld_ok;
         rsp_rdata     <= ld_ok ? ld_val : '0;
         rsp_align_err <= req_valid & ~legal;
      end
   end

   // R4: a legal load is answered in the next cycle
   a_r4_load_resp: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_we && legal) |=> rsp_valid);
   // R4: no data leaks while no response is presented
   a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (rsp_rdata == '0));
   // R3: an alignment error never comes with data
   a_r3_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_align_err |-> !rsp_valid);
   // R11: stores stay silent on the response side
   a_r11_store_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_we) |=> !rsp_valid);
   // R3: a rejected request leaves the addressed row untouched
   a_r3_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !legal) |-> !wr_en);
endmodule

// File: tb/tb_lsu_lane_aligner.sv
module tb_lsu_lane_aligner;
   typedef struct packed {
      logic        we;
      logic [2:0]  sz;
      logic        sw;
      logic [63:0] addr;
      logic [63:0] wd;
      logic        ev;
      logic        ee;
      logic [63:0] er;
      logic [7:0]  rq;
   } vec_t;

   localparam int NV = 29;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 3'd3, 1'b0, 64'h08, 64'h8877665544332211, 1'b0, 1'b0, 64'h0, 8'd8},  // R8 full store
      '{1'b0, 3'd3, 1'b0, 64'h08, 64'h0, 1'b1, 1'b0, 64'h8877665544332211, 8'd6},  // R6 full load
      '{1'b0, 3'd0, 1'b0, 64'h0A, 64'h0, 1'b1, 1'b0, 64'h33, 8'd5},                // R5 byte
      '{1'b0, 3'd1, 1'b0, 64'h0C, 64'h0, 1'b1, 1'b0, 64'h6655, 8'd5},              // R5 half
      '{1'b0, 3'd2, 1'b0, 64'h0C, 64'h0, 1'b1, 1'b0, 64'h88776655, 8'd5},          // R5 word
      '{1'b0, 3'd1, 1'b1, 64'h0C, 64'h0, 1'b1, 1'b0, 64'h5566, 8'd9},              // R9 half swap
      '{1'b0, 3'd2, 1'b1, 64'h08, 64'h0, 1'b1, 1'b0, 64'h11223344, 8'd9},          // R9 word swap
      '{1'b1, 3'd0, 1'b0, 64'h09, 64'hFFFFFFFFFFFFFFAB, 1'b0, 1'b0, 64'h0, 8'd7},  // R7 byte store
      '{1'b0, 3'd3, 1'b0, 64'h08, 64'h0, 1'b1, 1'b0, 64'h887766554433AB11, 8'd7},  // R7 readback
      '{1'b1, 3'd1, 1'b1, 64'h0E, 64'h1234, 1'b0, 1'b0, 64'h0, 8'd9},              // R9 store swap
      '{1'b0, 3'd3, 1'b0, 64'h08, 64'h0, 1'b1, 1'b0, 64'h341266554433AB11, 8'd9},  // R9 readback
      '{1'b1, 3'd1, 1'b0, 64'h0B, 64'hBEEF, 1'b0, 1'b1, 64'h0, 8'd3},              // R3 misaligned store
      '{1'b0, 3'd3, 1'b0, 64'h08, 64'h0, 1'b1, 1'b0, 64'h341266554433AB11, 8'd3},  // R3 row unchanged
      '{1'b0, 3'd2, 1'b0, 64'h0A, 64'h0, 1'b0, 1'b1, 64'h0, 8'd3},                 // R3 misaligned load
      '{1'b0, 3'd5, 1'b0, 64'h08, 64'h0, 1'b0, 1'b1, 64'h0, 8'd2},                 // R2 bad code load
      '{1'b1, 3'd7, 1'b0, 64'h08, 64'h0, 1'b0, 1'b1, 64'h0, 8'd2},                 // R2 bad code store
      '{1'b0, 3'd3, 1'b0, 64'h08, 64'h0, 1'b1, 1'b0, 64'h341266554433AB11, 8'd2},  // R2 row unchanged
      '{1'b0, 3'd3, 1'b0, 64'h30, 64'h0, 1'b1, 1'b0, 64'h0, 8'd10},                // R10 unwritten row
      '{1'b1, 3'd2, 1'b0, 64'h14, 64'hDEADBEEF, 1'b0, 1'b0, 64'h0, 8'd7},          // R7 word store
      '{1'b0, 3'd3, 1'b0, 64'h10, 64'h0, 1'b1, 1'b0, 64'hDEADBEEF00000000, 8'd7},  // R7 readback
      '{1'b0, 3'd3, 1'b1, 64'h10, 64'h0, 1'b1, 1'b0, 64'h00000000EFBEADDE, 8'd9},  // R9 full swap
      '{1'b0, 3'd3, 1'b0, 64'h1000000000000010, 64'h0, 1'b1, 1'b0, 64'hDEADBEEF00000000, 8'd1}, // R1
      '{1'b0, 3'd2, 1'b0, 64'h94, 64'h0, 1'b1, 1'b0, 64'hDEADBEEF, 8'd1},          // R1 wrap
      '{1'b1, 3'd3, 1'b1, 64'h18, 64'h0102030405060708, 1'b0, 1'b0, 64'h0, 8'd9},  // R9 full store swap
      '{1'b0, 3'd0, 1'b0, 64'h18, 64'h0, 1'b1, 1'b0, 64'h01, 8'd5},                // R5 offset 0
      '{1'b0, 3'd0, 1'b0, 64'h1F, 64'h0, 1'b1, 1'b0, 64'h08, 8'd5},                // R5 offset 7
      '{1'b0, 3'd0, 1'b0, 64'h01, 64'h0, 1'b1, 1'b0, 64'h0, 8'd10},                // R10 row 0 blank
      '{1'b0, 3'd1, 1'b0, 64'h1E, 64'h0, 1'b1, 1'b0, 64'h0807, 8'd5},              // R5 top half
      '{1'b0, 3'd3, 1'b0, 64'h1C, 64'h0, 1'b0, 1'b1, 64'h0, 8'd3}                  // R3 dword misaligned
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_we = 1'b0;
   logic [2:0]  req_size = 3'd0;
   logic        req_swap = 1'b0;
   logic [63:0] req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic        rsp_valid;
   logic [63:0] rsp_rdata;
   logic        rsp_align_err;
   int          n_chk = 0;
   int          n_bad = 0;

   always #4 clk = ~clk;

   lsu_lane_aligner dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
      .req_size(req_size), .req_swap(req_swap), .req_addr(req_addr),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .rsp_align_err(rsp_align_err)
   );

   task automatic check_rsp(input int rq, input logic ev, input logic ee, input logic [63:0] er);
      n_chk++;
      if (rsp_valid !== ev || rsp_align_err !== ee || rsp_rdata !== er) begin
         n_bad++;
         $display("FAIL R%0d: got valid=%b err=%b data=%h, expected valid=%b err=%b data=%h",
                  rq, rsp_valid, rsp_align_err, rsp_rdata, ev, ee, er);
      end
   endtask

   task automatic drive(input logic we, input logic [2:0] sz, input logic sw,
                        input logic [63:0] a, input logic [63:0] wd);
      req_valid = 1'b1; req_we = we; req_size = sz; req_swap = sw;
      req_addr = a; req_wdata = wd;
   endtask

   task automatic idle();
      req_valid = 1'b0; req_we = 1'b0; req_wdata = '0;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      // R10: outputs low under reset
      repeat (3) @(negedge clk);
      check_rsp(10, 1'b0, 1'b0, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check_rsp(10, 1'b0, 1'b0, 64'h0);

      // vector table
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         drive(VEC[v].we, VEC[v].sz, VEC[v].sw, VEC[v].addr, VEC[v].wd);
         @(negedge clk);
         idle();
         check_rsp(int'(VEC[v].rq), VEC[v].ev, VEC[v].ee, VEC[v].er);
      end

      // R4: response lasts one cycle, data returns to zero afterwards
      @(negedge clk);
      check_rsp(4, 1'b0, 1'b0, 64'h0);

      // R7 / R4: store immediately followed by a load of the same row
      drive(1'b1, 3'd0, 1'b0, 64'h23, 64'h5A);
      @(negedge clk);
      check_rsp(11, 1'b0, 1'b0, 64'h0);
      drive(1'b0, 3'd1, 1'b0, 64'h22, 64'h0);
      @(negedge clk);
      idle();
      check_rsp(7, 1'b1, 1'b0, 64'h5A00);

      // R3: alignment error pulse lasts exactly one cycle
      drive(1'b0, 3'd1, 1'b0, 64'h21, 64'h0);
      @(negedge clk);
      idle();
      check_rsp(3, 1'b0, 1'b1, 64'h0);
      @(negedge clk);
      check_rsp(3, 1'b0, 1'b0, 64'h0);

      // R10: reset in mid-run clears written rows
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      drive(1'b0, 3'd3, 1'b0, 64'h08, 64'h0);
      @(negedge clk);
      idle();
      check_rsp(10, 1'b1, 1'b0, 64'h0);

      @(negedge clk);
      finish_run();
   end
endmodule